// File: doc/BRIEF.md
# Packet Report Length Truncator

This block copies the leading octets of every received packet onto a report stream. The input is a byte stream in which each valid beat carries one octet, with flags marking the first and the last octet of a packet. The output is the same stream, one cycle later. It stops once a programmed number of octets has been forwarded. The block then raises its own end flag on the final forwarded octet and discards the remainder of the input packet.

The host sets the forwarding length through a byte-wide port with two write strobes. The low-byte strobe stages the low eight bits. The high-byte strobe then commits the whole value. Only 11 bits of the 16 are kept. The programmed value is mapped to an effective limit:
- settings below 14 give 14 octets;
- settings from 14 to 1535 give exactly that many octets;
- settings above 1535 disable truncation.

The effective limit is captured when a packet starts, so a packet is never cut to two different lengths.

Top module: `pkt_report_trunc`

## Requirements
- R1: After reset, out_valid is low and the programmed length is 0, so the first packet is forwarded as 14 octets.
- R2: A low-byte write only stages len_wdata; the programmed length changes when a high-byte write commits {len_wdata[2:0], staged low byte}. Bits 7:3 of the high byte are ignored.
- R3: A programmed value below 14 forwards 14 octets of a longer packet.
- R4: A programmed value N from 14 to 1535 forwards exactly N octets of a longer packet, including N = 1535.
- R5: A programmed value from 1536 to 2047 forwards every octet of the packet, with no cut.
- R6: A packet shorter than or equal to the effective limit is forwarded whole, and out_eop is set on its own last octet.
- R7: When a packet is cut, out_eop is set on the last forwarded octet, and no further out_valid beat appears for the rest of that input packet.
- R8: A length commit made while a packet is in flight does not change that packet's limit; the new value applies from the next in_sop.
- R9: Each forwarded beat appears on the outputs exactly one cycle after its input beat. The data is unchanged, and out_sop is set on the first octet only.
- R10: An in_sop that arrives before the current packet's end starts a new packet, with a fresh count and a fresh limit; the abandoned packet gets no out_eop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_lo_we | input | 1 | Stage low length byte |
| len_hi_we | input | 1 | Commit high length byte together with staged low byte |
| len_wdata | input | 8 | Length write data |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First octet of a packet |
| in_eop | input | 1 | Last octet of a packet |
| in_data | input | DATA_W | Input octet |
| out_valid | output | 1 | Report beat valid |
| out_sop | output | 1 | First report octet |
| out_eop | output | 1 | Last report octet |
| out_data | output | DATA_W | Report octet |

## Verification
The bench checks the clamp edges at 13, 14, 1535 and 1536. An off-by-one comparison there would send one octet too many or too few, or would cut a packet that should go through whole. It checks a commit made in the middle of a packet, to catch a design that applies a new length to the packet already in flight. It also checks a length written with only the low strobe and a length with stray high bits, which expose a design that commits early or keeps more than 11 bits. Finally, it checks a restart caused by a second start flag, and a packet shorter than the limit. In both cases a faulty design would carry over a stale count, or would drop or misplace the end flag.

// File: rtl/pkt_trunc_pkg.sv
package pkt_trunc_pkg;

    // Width of the host-visible length field (bits kept from the 16-bit write)
    localparam int PKT_LEN_W = 11;

    typedef logic [PKT_LEN_W-1:0] pkt_len_t;

    // Effective limit derived from the programmed length
    typedef struct packed {
        logic     nolim;  // 1: forward the whole packet
        pkt_len_t lim;    // octets to forward when nolim is 0
    } pkt_limit_t;

endpackage

// File: rtl/pkt_len_reg.sv
module pkt_len_reg
    import pkt_trunc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    output pkt_len_t          prog_len
);
    localparam int HI_BITS = PKT_LEN_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo_stage;
        pkt_len_t          prog;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we) begin
            st_d.lo_stage = wdata;
        end
        if (hi_we) begin
            st_d.prog = {wdata[HI_BITS-1:0], st_q.lo_stage};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_len = st_q.prog;

    // R2
    lo_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we) |=> $stable(prog_len));

    // R2
    hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we) |=> (prog_len[PKT_LEN_W-1:BYTE_W] == $past(wdata[HI_BITS-1:0])));

endmodule

// File: rtl/pkt_len_clamp.sv
module pkt_len_clamp
    import pkt_trunc_pkg::*;
#(
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 1535
) (
    input  pkt_len_t   prog_len,
    output pkt_limit_t limit
);
    localparam pkt_len_t MIN_V = pkt_len_t'(MIN_LEN);
    localparam pkt_len_t MAX_V = pkt_len_t'(MAX_LEN);

    always_comb begin
        limit.nolim = 1'b0;
        limit.lim   = prog_len;
        if (prog_len < MIN_V) begin
            limit.lim = MIN_V;
        end else if (prog_len > MAX_V) begin
            limit.nolim = 1'b1;
            limit.lim   = MAX_V;
        end
    end

    // R3
    clamp_floor_chk: assert final (limit.nolim || (limit.lim >= MIN_V));

endmodule

// File: rtl/pkt_trunc_core.sv
module pkt_trunc_core
    import pkt_trunc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 1535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pkt_limit_t        limit,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    localparam pkt_len_t ONE = pkt_len_t'(1);

    typedef struct packed {
        logic              active;  // forwarding the current packet
        logic              nolim;   // limit captured at start: no cut
        pkt_len_t          cnt;     // octets forwarded so far
        pkt_len_t          lim;     // limit captured at start
        logic              ov;
        logic              osop;
        logic              oeop;
        logic [DATA_W-1:0] odata;
    } core_st_t;

    core_st_t st_d, st_q;
    pkt_len_t cnt_inc;
    logic     cut;

    always_comb begin
        st_d       = st_q;
        st_d.ov    = 1'b0;
        st_d.osop  = 1'b0;
        st_d.oeop  = 1'b0;
        st_d.odata = in_data;
        cnt_inc    = st_q.cnt + ONE;
        cut        = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                cut         = !limit.nolim && (limit.lim == ONE);
                st_d.nolim  = limit.nolim;
                st_d.lim    = limit.lim;
                st_d.cnt    = ONE;
                st_d.ov     = 1'b1;
                st_d.osop   = 1'b1;
                st_d.oeop   = in_eop || cut;
                st_d.active = !(in_eop || cut);
            end else if (st_q.active) begin
                cut         = !st_q.nolim && (cnt_inc == st_q.lim);
                st_d.cnt    = st_q.nolim ? st_q.cnt : cnt_inc;
                st_d.ov     = 1'b1;
                st_d.oeop   = in_eop || cut;
                st_d.active = !(in_eop || cut);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_sop   = st_q.osop;
    assign out_eop   = st_q.oeop;
    assign out_data  = st_q.odata;

    // R7
    cnt_below_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.nolim) |-> (st_q.cnt < st_q.lim));

    // R7
    drop_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && !st_q.active) |=> !out_valid);

    // R9
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    // R9
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (out_valid && out_sop && out_data == $past(in_data)));

    // R8
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !(in_valid && in_sop)) |=> $stable(st_q.lim));

    // R4
    lim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.nolim) |->
            (st_q.lim >= pkt_len_t'(MIN_LEN) && st_q.lim <= pkt_len_t'(MAX_LEN)));

endmodule

// File: rtl/pkt_report_trunc.sv
module pkt_report_trunc
    import pkt_trunc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 1535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_lo_we,
    input  logic              len_hi_we,
    input  logic [7:0]        len_wdata,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    pkt_len_t   prog_len;
    pkt_limit_t limit;

    pkt_len_reg #(.BYTE_W(8)) len_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (len_lo_we),
        .hi_we    (len_hi_we),
        .wdata    (len_wdata),
        .prog_len (prog_len)
    );

    pkt_len_clamp #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) clamp_i (
        .prog_len (prog_len),
        .limit    (limit)
    );

    pkt_trunc_core #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .limit     (limit),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

endmodule

// File: tb/pkt_report_trunc_tb_top.sv
module pkt_report_trunc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len_lo_we = 1'b0;
    logic       len_hi_we = 1'b0;
    logic [7:0] len_wdata = '0;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_sop;
    logic       out_eop;
    logic [7:0] out_data;

    int total = 0;
    int bad   = 0;

    // capture of output beats
    int       n_out = 0;
    logic [7:0] cap_data [0:4095];
    logic       cap_sop  [0:4095];
    logic       cap_eop  [0:4095];

    always #2.5 clk = ~clk;  // 200 MHz

    pkt_report_trunc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_lo_we (len_lo_we),
        .len_hi_we (len_hi_we),
        .len_wdata (len_wdata),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < 4096) begin
            cap_data[n_out] = out_data;
            cap_sop[n_out]  = out_sop;
            cap_eop[n_out]  = out_eop;
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_len(input int v);
        @(negedge clk);
        len_lo_we = 1'b1; len_wdata = v[7:0];
        @(negedge clk);
        len_lo_we = 1'b0; len_hi_we = 1'b1; len_wdata = v[15:8];
        @(negedge clk);
        len_hi_we = 1'b0;
    endtask

    // Drive one packet; optionally commit new length (upd_val) during beats 3 and 4.
    // with_eop = 0 leaves the packet unterminated.
    task automatic drive_pkt(input int len, input int seed, input bit with_eop,
                             input bit upd, input int upd_val);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == len - 1);
            in_data  = 8'((seed + i) & 8'hFF);
            len_lo_we = upd && (i == 3);
            len_hi_we = upd && (i == 4);
            len_wdata = (i == 3) ? upd_val[7:0] : upd_val[15:8];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        len_lo_we = 1'b0; len_hi_we = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Check captured beats against one packet of exp_n octets starting at seed
    task automatic check_pkt(input string req, input int exp_n, input int seed);
        int derr = 0;
        int serr = 0;
        int eerr = 0;
        chk(n_out == exp_n, {req, " octet count"}, n_out, exp_n);
        for (int i = 0; i < n_out && i < exp_n; i++) begin
            if (cap_data[i] != 8'((seed + i) & 8'hFF)) derr++;
            if (cap_sop[i] != (i == 0)) serr++;
            if (cap_eop[i] != (i == exp_n - 1)) eerr++;
        end
        chk(derr == 0, {req, " data mismatches"}, derr, 0);
        chk(serr == 0, {req, " sop placement"}, serr, 0);
        chk(eerr == 0, {req, " eop placement"}, eerr, 0);
    endtask

    task automatic run_case(input string req, input int pkt_len, input int exp_n, input int seed);
        n_out = 0;
        drive_pkt(pkt_len, seed, 1'b1, 1'b0, 0);
        settle();
        check_pkt(req, exp_n, seed);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        run_case("R1 default length", 30, 14, 8'h10);
    endtask

    task automatic t_floor();
        wr_len(5);
        run_case("R3 setting 5", 40, 14, 8'h20);
        wr_len(13);
        run_case("R3 setting 13", 40, 14, 8'h21);
    endtask

    task automatic t_exact();
        wr_len(14);
        run_case("R4 setting 14", 40, 14, 8'h30);
        wr_len(20);
        run_case("R4 setting 20", 40, 20, 8'h31);
        wr_len(1535);
        run_case("R4 setting 1535", 1600, 1535, 8'h32);
        // R7: cut packet yields no further beats (count above) and eop on last
    endtask

    task automatic t_nolimit();
        wr_len(1536);
        run_case("R5 setting 1536", 1600, 1600, 8'h40);
        wr_len(2047);
        run_case("R5 setting 2047", 100, 100, 8'h41);
    endtask

    task automatic t_regwrite();
        // high byte 0xF8 keeps only bits 2:0 -> 0x014 = 20
        wr_len(16'hF814);
        run_case("R2 high bits ignored", 40, 20, 8'h50);
        // low strobe alone must not change the limit
        @(negedge clk);
        len_lo_we = 1'b1; len_wdata = 8'd30;
        @(negedge clk);
        len_lo_we = 1'b0;
        run_case("R2 low-only staged", 40, 20, 8'h51);
        // high strobe now commits the staged 30
        @(negedge clk);
        len_hi_we = 1'b1; len_wdata = 8'h00;
        @(negedge clk);
        len_hi_we = 1'b0;
        run_case("R2 high commit", 40, 30, 8'h52);
    endtask

    task automatic t_short();
        wr_len(100);
        run_case("R6 short packet", 10, 10, 8'h60);
        run_case("R6 packet equal to limit", 100, 100, 8'h61);
    endtask

    task automatic t_midupdate();
        wr_len(20);
        n_out = 0;
        drive_pkt(60, 8'h70, 1'b1, 1'b1, 50);
        settle();
        check_pkt("R8 in-flight packet keeps old limit", 20, 8'h70);
        run_case("R8 next packet uses new limit", 60, 50, 8'h71);
    endtask

    task automatic t_restart();
        int sops = 0;
        int eops = 0;
        wr_len(20);
        n_out = 0;
        drive_pkt(10, 8'h80, 1'b0, 1'b0, 0);
        drive_pkt(30, 8'h90, 1'b1, 1'b0, 0);
        settle();
        chk(n_out == 30, "R10 beats across restart", n_out, 30);
        for (int i = 0; i < n_out; i++) begin
            if (cap_sop[i]) sops++;
            if (cap_eop[i]) eops++;
        end
        chk(sops == 2, "R10 start flags", sops, 2);
        chk(eops == 1, "R10 single end flag", eops, 1);
        chk(n_out > 29 && cap_eop[29] && cap_sop[10], "R10 restart positions",
            (n_out > 29) ? int'(cap_eop[29]) : 0, 1);
        chk(n_out > 10 && cap_data[10] == 8'h90, "R9 data after restart",
            (n_out > 10) ? int'(cap_data[10]) : -1, 8'h90);
    endtask

    task automatic t_latency();
        wr_len(20);
        n_out = 0;
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_data = 8'hA5;
        @(negedge clk);
        // the beat was registered at the edge just passed
        chk(out_valid && out_sop && out_data == 8'hA5, "R9 one-cycle latency",
            int'(out_data), 8'hA5);
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        chk(out_valid && !out_sop && out_eop && out_data == 8'h5A, "R9 second beat",
            int'(out_data), 8'h5A);
        @(negedge clk);
        chk(!out_valid, "R9 idle after packet", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_floor();
        t_exact();
        t_nolimit();
        t_regwrite();
        t_short();
        t_midupdate();
        t_restart();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule